// File: doc/BRIEF.md
# Burst-of-Four Double-Data-Rate SRAM

A cycle-accurate, synthesizable model of a common-I/O SRAM that moves four words for every accepted command. A command is taken on the rising clock edge when the active-low load input is low. The read/write input selects its direction. The block walks the two low address bits itself, so the host supplies only the start address. Each clock carries two data beats. The port view is per clock: the even beat of the pair sits in the low half of a doubled-width data vector and the odd beat sits in the high half. Read data and its output-enable come from registers. The enable goes low in the first cycle that carries no read beat.

Writes are posted. The address of an accepted write is staged. Its four beats and per-lane enables collect in a buffer over the next two clocks. The buffer is written into the array only when the next write begins delivering data, so a read can follow a write at the next command slot with no idle cycle. A read whose word is still held in the buffer gets the newer bytes, but only in the lanes whose enables were active. The other lanes come from the array.

Top module: `ddr_b4_sram`

## Requirements
- R1: After reset `oe_o` is 0, `rdata_o` is zero, and every array word reads back as zero.
- R2: A command is accepted at a rising edge only if `ld_ni` is 0 there. While `ld_ni` is 1, no transfer starts, whatever `rw_i` and `addr_i` hold.
- R3: `ld_ni` low in the cycle right after an accepted command is ignored. No read beats and no array change come from it.
- R4: `rw_i` = 1 at acceptance makes a read and `rw_i` = 0 makes a write.
- R5: A burst transfers four words. Beat k (k = 0..3) uses the address whose upper bits equal the start address and whose two low bits are (start low bits + k) mod 4.
- R6: Write beats 0 and 1 are taken at the first edge after a write command, and beats 2 and 3 at the second. In each pair the even beat is on `wdata_i[DW-1:0]` with enables `bwe_ni[NB-1:0]`, and the odd beat is on the upper half with `bwe_ni[2*NB-1:NB]`. The enables are active low. Enable bit l covers data bits l*9 to l*9+8: bit 0 covers bits 8:0 and bit 1 covers bits 17:9.
- R7: For a read accepted at edge n, `rdata_o` holds beats 0 (low half) and 1 (high half) after edge n+2, and beats 2 and 3 after edge n+3. `oe_o` is 1 in both of those cycles.
- R8: In every cycle that carries no read beat, `oe_o` is 0 and `rdata_o` is zero.
- R9: A read accepted after a write returns that write's data, including when the write is still buffered. Disabled lanes keep their earlier contents.
- R10: A read accepted before a write returns the data from before that write, even when the write's beats arrive while the read is being returned.
- R11: Reads at consecutive command slots give four cycles of unbroken `oe_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Main clock; commands and data taken on rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ld_ni | input | 1 | Command load strobe, active low |
| rw_i | input | 1 | 1 = read, 0 = write |
| addr_i | input | AW | Burst start address |
| wdata_i | input | 2*DW | Write beat pair: even beat low, odd beat high |
| bwe_ni | input | 2*NB | Per-lane write enables, active low, even beat low |
| rdata_o | output | 2*DW | Read beat pair: even beat low, odd beat high |
| oe_o | output | 1 | High in cycles that carry read beats |

## Verification
The bench counts edges from each command's acceptance edge n. Write beats are driven for edges n+1 and n+2. Read results are due after edges n+2 and n+3, and `oe_o` must be low after n+4 unless another read follows. For every command issued, the bench records the expected output for those exact cycles, computed from its own model of the array and updated in issue order. It then compares `oe_o` and `rdata_o` one time unit after every rising edge. Cycles with no expectation must read idle, so an ignored command that still produced beats, or beats that arrive a cycle early or late, show up as mismatches.

// File: rtl/b4sram_pkg.sv
package b4sram_pkg;
  typedef enum logic {OP_WRITE = 1'b0, OP_READ = 1'b1} op_e;
  localparam int BURST_LEN = 4;
  localparam int PAIR      = 2;
endpackage

// File: rtl/b4sram_cmd_seq.sv
module b4sram_cmd_seq
  import b4sram_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_ni,
  input  logic          rw_i,
  input  logic [AW-1:0] addr_i,
  output logic          wr_first_o,
  output logic          wr_second_o,
  output logic [AW-1:0] wr_addr_o,
  output logic          rd_first_o,
  output logic          rd_second_o,
  output logic [AW-1:0] rd_addr_a_o,
  output logic [AW-1:0] rd_addr_b_o
);
  logic busy_q, accept;
  op_e  op;
  logic wq0, wq1, rp0, rp1, rp2;
  logic [AW-1:0] wa_q, ra0, ra1, ra2;

  assign op     = op_e'(rw_i);
  assign accept = !ld_ni && !busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      {wq0, wq1, rp0, rp1, rp2} <= '0;
      wa_q <= '0; ra0 <= '0; ra1 <= '0; ra2 <= '0;
    end else begin
      busy_q <= accept;
      wq0    <= accept && (op == OP_WRITE);
      wq1    <= wq0;
      rp0    <= accept && (op == OP_READ);
      rp1    <= rp0;
      rp2    <= rp1;
      if (accept && op == OP_WRITE) wa_q <= addr_i;
      if (accept && op == OP_READ)  ra0  <= addr_i;
      ra1 <= ra0;
      ra2 <= ra1;
    end
  end

  assign wr_first_o  = wq0;
  assign wr_second_o = wq1;
  assign wr_addr_o   = wa_q;
  assign rd_first_o  = rp1;
  assign rd_second_o = rp2;
  assign rd_addr_a_o = ra1;
  assign rd_addr_b_o = ra2;

  // R3
  cmd_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> !accept);
  // R6
  wr_half_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wq1 |-> $past(wq0));
endmodule

// File: rtl/b4sram_wbuf.sv
module b4sram_wbuf
  import b4sram_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 18,
  parameter int NB = 2
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 first_i,
  input  logic                                 second_i,
  input  logic [AW-1:0]                        addr_i,
  input  logic [PAIR*DW-1:0]                   wdata_i,
  input  logic [PAIR*NB-1:0]                   bwe_ni,
  output logic                                 commit_o,
  output logic [AW-1:0]                        cmt_addr_o,
  output logic [BURST_LEN-1:0][DW-1:0]         cmt_data_o,
  output logic [BURST_LEN-1:0][NB-1:0]         cmt_en_o,
  input  logic [PAIR-1:0][AW-1:0]              raddr_i,
  input  logic [PAIR-1:0][DW-1:0]              arr_i,
  output logic [PAIR-1:0][DW-1:0]              fwd_o
);
  localparam int LW = DW / NB;

  logic                             valid_q;
  logic [AW-1:0]                    addr_q;
  logic [BURST_LEN-1:0][DW-1:0]     data_q;
  logic [BURST_LEN-1:0][NB-1:0]     en_q;
  logic [BURST_LEN-1:0][AW-1:0]     slot_addr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
      en_q    <= '0;
    end else if (first_i) begin
      valid_q   <= 1'b1;
      addr_q    <= addr_i;
      data_q[0] <= wdata_i[DW-1:0];
      data_q[1] <= wdata_i[PAIR*DW-1:DW];
      en_q[0]   <= ~bwe_ni[NB-1:0];
      en_q[1]   <= ~bwe_ni[PAIR*NB-1:NB];
      en_q[2]   <= '0;
      en_q[3]   <= '0;
    end else if (second_i) begin
      data_q[2] <= wdata_i[DW-1:0];
      data_q[3] <= wdata_i[PAIR*DW-1:DW];
      en_q[2]   <= ~bwe_ni[NB-1:0];
      en_q[3]   <= ~bwe_ni[PAIR*NB-1:NB];
    end
  end

  // Previous burst drains to the array as the next one starts filling.
  assign commit_o   = first_i && valid_q;
  assign cmt_addr_o = addr_q;
  assign cmt_data_o = data_q;
  assign cmt_en_o   = en_q;

  always_comb begin
    for (int k = 0; k < BURST_LEN; k++)
      slot_addr[k] = {addr_q[AW-1:2], addr_q[1:0] + 2'(k)};
  end

  always_comb begin
    for (int j = 0; j < PAIR; j++) begin
      fwd_o[j] = arr_i[j];
      for (int k = 0; k < BURST_LEN; k++)
        if (valid_q && slot_addr[k] == raddr_i[j])
          for (int l = 0; l < NB; l++)
            if (en_q[k][l]) fwd_o[j][l*LW +: LW] = data_q[k][l*LW +: LW];
    end
  end

  // R9
  buf_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> valid_q);
endmodule

// File: rtl/b4sram_mem.sv
module b4sram_mem
  import b4sram_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 18,
  parameter int NB = 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         we_i,
  input  logic [AW-1:0]                base_i,
  input  logic [BURST_LEN-1:0][DW-1:0] data_i,
  input  logic [BURST_LEN-1:0][NB-1:0] en_i,
  input  logic [PAIR-1:0][AW-1:0]      raddr_i,
  output logic [PAIR-1:0][DW-1:0]      rdata_o
);
  localparam int DEPTH = 1 << AW;
  localparam int LW    = DW / NB;

  logic [DW-1:0] mem_q [DEPTH];
  logic [BURST_LEN-1:0][AW-1:0] waddr;

  always_comb begin
    for (int k = 0; k < BURST_LEN; k++)
      waddr[k] = {base_i[AW-1:2], base_i[1:0] + 2'(k)};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int w = 0; w < DEPTH; w++) mem_q[w] <= '0;
    end else if (we_i) begin
      for (int k = 0; k < BURST_LEN; k++)
        for (int l = 0; l < NB; l++)
          if (en_i[k][l]) mem_q[waddr[k]][l*LW +: LW] <= data_i[k][l*LW +: LW];
    end
  end

  for (genvar j = 0; j < PAIR; j++) begin : g_rd
    assign rdata_o[j] = mem_q[raddr_i[j]];
  end
endmodule

// File: rtl/ddr_b4_sram.sv
module ddr_b4_sram
  import b4sram_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 18,
  parameter int NB = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ld_ni,
  input  logic               rw_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [2*DW-1:0]    wdata_i,
  input  logic [2*NB-1:0]    bwe_ni,
  output logic [2*DW-1:0]    rdata_o,
  output logic               oe_o
);
  logic          wr_first, wr_second, rd_first, rd_second;
  logic [AW-1:0] wr_addr, rd_addr_a, rd_addr_b;
  logic          commit;
  logic [AW-1:0] cmt_addr;
  logic [BURST_LEN-1:0][DW-1:0] cmt_data;
  logic [BURST_LEN-1:0][NB-1:0] cmt_en;
  logic [PAIR-1:0][AW-1:0] raddr;
  logic [PAIR-1:0][DW-1:0] arr_word, fwd_word;
  logic [AW-1:0] rbase;
  logic [1:0]    rofs;

  b4sram_cmd_seq #(.AW(AW)) u_seq (
    .clk_i, .rst_ni, .ld_ni, .rw_i, .addr_i,
    .wr_first_o (wr_first),  .wr_second_o(wr_second), .wr_addr_o(wr_addr),
    .rd_first_o (rd_first),  .rd_second_o(rd_second),
    .rd_addr_a_o(rd_addr_a), .rd_addr_b_o(rd_addr_b)
  );

  b4sram_wbuf #(.AW(AW), .DW(DW), .NB(NB)) u_wbuf (
    .clk_i, .rst_ni,
    .first_i(wr_first), .second_i(wr_second), .addr_i(wr_addr),
    .wdata_i, .bwe_ni,
    .commit_o(commit), .cmt_addr_o(cmt_addr), .cmt_data_o(cmt_data), .cmt_en_o(cmt_en),
    .raddr_i(raddr), .arr_i(arr_word), .fwd_o(fwd_word)
  );

  b4sram_mem #(.AW(AW), .DW(DW), .NB(NB)) u_mem (
    .clk_i, .rst_ni,
    .we_i(commit), .base_i(cmt_addr), .data_i(cmt_data), .en_i(cmt_en),
    .raddr_i(raddr), .rdata_o(arr_word)
  );

  always_comb begin
    rbase = rd_first ? rd_addr_a : rd_addr_b;
    rofs  = rd_first ? 2'd0 : 2'd2;
    for (int j = 0; j < PAIR; j++)
      raddr[j] = {rbase[AW-1:2], rbase[1:0] + rofs + 2'(j)};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oe_o    <= 1'b0;
      rdata_o <= '0;
    end else begin
      oe_o    <= rd_first || rd_second;
      rdata_o <= (rd_first || rd_second) ? {fwd_word[1], fwd_word[0]} : '0;
    end
  end

  // R8
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_o |-> rdata_o == '0);
  // R7
  burst_two_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_o) |=> oe_o);
endmodule

// File: tb/ddr_b4_sram_tb.sv
module ddr_b4_sram_tb;
  localparam int AW = 4, DW = 18, NB = 2, NC = 4096;

  logic clk = 0, rst_ni = 0, ld_ni = 1, rw_i = 0;
  logic [AW-1:0] addr_i = '0;
  logic [2*DW-1:0] wdata_i = '0;
  logic [2*NB-1:0] bwe_ni = '1;
  logic [2*DW-1:0] rdata_o;
  logic oe_o;

  ddr_b4_sram #(.AW(AW), .DW(DW), .NB(NB)) u_dut (
    .clk_i(clk), .rst_ni, .ld_ni, .rw_i, .addr_i, .wdata_i, .bwe_ni, .rdata_o, .oe_o);

  always #2 clk = ~clk;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit done = 0;
  logic [DW-1:0] model [16];
  logic exp_oe [NC];
  logic [2*DW-1:0] exp_rd [NC];
  string exp_tag [NC];
  logic [2*DW-1:0] sched_wd [NC];
  logic [2*NB-1:0] sched_bwe [NC];
  logic cur_ld = 1, cur_rw = 0;
  logic [AW-1:0] cur_addr = '0;

  // {rd, addr[3:0], bwe_n[7:0] (beat k lanes at [2k+1:2k]), seed[17:0]}
  localparam logic [30:0] VEC [12] = '{
    {1'b0, 4'h0, 8'h00, 18'h12345}, {1'b0, 4'h5, 8'h00, 18'h2abcd},
    {1'b0, 4'ha, 8'h00, 18'h0f0f0}, {1'b0, 4'hf, 8'h00, 18'h35a5a},
    {1'b1, 4'h0, 8'h00, 18'h0},     {1'b1, 4'h5, 8'h00, 18'h0},
    {1'b1, 4'ha, 8'h00, 18'h0},     {1'b1, 4'hf, 8'h00, 18'h0},
    {1'b0, 4'h6, 8'h69, 18'h3c3c3}, {1'b1, 4'h4, 8'h00, 18'h0},
    {1'b1, 4'h7, 8'h00, 18'h0},     {1'b1, 4'h2, 8'h00, 18'h0}
  };

  function automatic logic [AW-1:0] baddr(logic [AW-1:0] a, int k);
    return {a[3:2], a[1:0] + 2'(k)};
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic step();
    @(negedge clk);
    ld_ni = cur_ld; rw_i = cur_rw; addr_i = cur_addr;
    wdata_i = sched_wd[cyc]; bwe_ni = sched_bwe[cyc];
    @(posedge clk); #1;
    check(exp_tag[cyc], 64'({oe_o, rdata_o}), 64'({exp_oe[cyc], exp_rd[cyc]}));
    cur_ld = 1;
    cyc++;
  endtask

  task automatic wr(logic [AW-1:0] a, logic [3:0][DW-1:0] d, logic [7:0] bn);
    cur_ld = 0; cur_rw = 0; cur_addr = a;
    sched_wd[cyc+1] = {d[1], d[0]}; sched_bwe[cyc+1] = bn[3:0];
    sched_wd[cyc+2] = {d[3], d[2]}; sched_bwe[cyc+2] = bn[7:4];
    for (int k = 0; k < 4; k++)
      for (int l = 0; l < NB; l++)
        if (!bn[2*k+l]) model[baddr(a, k)][l*9 +: 9] = d[k][l*9 +: 9];
    step();
  endtask

  task automatic rd(logic [AW-1:0] a, string tag);
    cur_ld = 0; cur_rw = 1; cur_addr = a;
    exp_oe[cyc+2] = 1; exp_rd[cyc+2] = {model[baddr(a, 1)], model[baddr(a, 0)]};
    exp_oe[cyc+3] = 1; exp_rd[cyc+3] = {model[baddr(a, 3)], model[baddr(a, 2)]};
    exp_tag[cyc+2] = tag; exp_tag[cyc+3] = tag;
    step();
  endtask

  function automatic logic [3:0][DW-1:0] mk(logic [DW-1:0] s);
    logic [3:0][DW-1:0] d;
    for (int k = 0; k < 4; k++) d[k] = s + 18'(k * 18'h0d3);
    return d;
  endfunction

  initial begin
    #(4 * 50000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NC; i++) begin
      exp_oe[i] = 0; exp_rd[i] = '0; exp_tag[i] = "R8";
      sched_wd[i] = '0; sched_bwe[i] = '1;
    end
    for (int i = 0; i < 16; i++) model[i] = '0;
    #7;
    check("R1", 64'({oe_o, rdata_o}), 64'd0);
    @(negedge clk); rst_ni = 1;

    rd(4'h9, "R1"); step(); step(); step(); step();

    // table: writes from every start offset, readback with wrap (R5, R6, R4)
    for (int v = 0; v < 12; v++) begin
      if (VEC[v][30]) rd(VEC[v][29:26], "R5");
      else wr(VEC[v][29:26], mk(VEC[v][17:0]), VEC[v][25:18]);
      step();
    end
    repeat (4) step();

    // R9: read in the next slot after a partial write, same word
    wr(4'h8, mk(18'h1ffff), 8'b10_00_01_00); step();
    rd(4'h8, "R9"); step(); repeat (4) step();

    // R10: read issued just before a write to the same words
    rd(4'h9, "R10"); step();
    wr(4'h9, mk(18'h0aaaa), 8'h00); step(); repeat (4) step();
    rd(4'h9, "R9"); step(); repeat (4) step();

    // R9: consecutive writes, first one drained by second, then reads
    wr(4'hc, mk(18'h11111), 8'h00); step();
    wr(4'h1, mk(18'h22222), 8'h00); step();
    rd(4'hc, "R9"); step();
    rd(4'h1, "R9"); step(); repeat (4) step();

    // R9: two writes to same words, second partial, merged on read
    wr(4'h3, mk(18'h33333), 8'h00); step();
    wr(4'h3, mk(18'h04444), 8'b01_10_01_10); step();
    rd(4'h3, "R9"); step(); repeat (4) step();

    // R11: reads at consecutive slots
    rd(4'h0, "R11"); step();
    rd(4'hd, "R11"); step(); repeat (4) step();

    // R3: load low in the busy cycle after a read is ignored
    rd(4'h5, "R3");
    cur_ld = 0; cur_rw = 0; cur_addr = 4'h6;
    sched_wd[cyc+1] = '1; sched_bwe[cyc+1] = '0;
    sched_wd[cyc+2] = '1; sched_bwe[cyc+2] = '0;
    step(); repeat (4) step();
    rd(4'h6, "R3"); step(); repeat (4) step();
    rd(4'h0, "R3");
    cur_ld = 0; cur_rw = 1; cur_addr = 4'hb;
    step(); repeat (5) step();

    // R2: load held high with other inputs toggling: nothing starts
    for (int i = 0; i < 6; i++) begin
      cur_rw = i[0]; cur_addr = 4'(i * 3);
      step();
    end
    cur_rw = 0;

    // R1: mid-run reset clears the array
    @(negedge clk); rst_ni = 0; #1;
    check("R1", 64'({oe_o, rdata_o}), 64'd0);
    for (int i = 0; i < 16; i++) model[i] = '0;
    @(negedge clk); rst_ni = 1;
    rd(4'h5, "R1"); step(); repeat (4) step();

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule